// File: doc/BRIEF.md
# Addressable Bit Register with Routing Mode

This block is a small bank of single-bit storage cells that is loaded one bit at a time from a serial data input. A binary address picks the one cell that a write touches, so a controller can assemble a parallel word from a serial stream, or change a single control line without disturbing its neighbours. The whole bank is visible at once on a parallel output word.

Two control inputs, an active-low enable and an active-high clear, choose one of four modes on every rising clock edge. In hold mode nothing changes. In write mode the addressed cell takes the data bit. In routing mode the bank acts as a one-to-N demultiplexer: the addressed output carries the data bit and every other output is driven low. In zero mode the whole bank is cleared. The state is a plain clocked register, so every mode's effect shows one cycle after its inputs are sampled. A synchronous reset, separate from the clear control, also empties the bank. The bank width is a parameter (8 cells with a 3-bit address by default, 4 cells with a 2-bit address as the small variant). Callers should move the address only while in hold mode; a multi-bit address change during write mode may land the data in a cell that was never meant.

Top module: `sel_bit_register`

## Requirements
- R1: While `rst` is high at a rising edge, `q` becomes all zeros on that edge, whatever the control inputs are.
- R2: With `en_n`=1 and `clr`=0 (hold mode), `q` keeps its value across the edge regardless of `din` and `addr`.
- R3: With `en_n`=0 and `clr`=0 (write mode), bit `q[addr]` takes the value of `din` one cycle after sampling.
- R4: In write mode every bit of `q` other than `q[addr]` keeps its previous value.
- R5: With `en_n`=0 and `clr`=1 (routing mode), after the edge `q[addr]` equals `din` and every other bit of `q` is 0.
- R6: With `en_n`=1 and `clr`=1 (zero mode), `q` becomes all zeros after the edge.
- R7: On entering hold mode from routing or zero mode, `q` keeps exactly the word that mode left behind (all zeros after zero mode, the routed pattern after routing mode).
- R8: The address is plain binary: address value k selects output bit `q[k]`, with `q[0]` as the least significant bit.
- R9: With `WIDTH`=4 the address is 2 bits wide and R2 to R8 hold unchanged over the four cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears the bank |
| din | input | 1 | Serial data bit written or routed to the addressed cell |
| addr | input | $clog2(WIDTH) | Binary index of the selected cell |
| en_n | input | 1 | Active-low enable for write and routing modes |
| clr | input | 1 | Active-high clear; selects routing or zero mode |
| q | output | WIDTH | Parallel word of all cells |

## Verification
The bench goes after the cells that must not change. A write that leaks into a neighbour, or an address decoder with a bit swapped, shows up as a wrong bit outside the target after a directed walk over every address. Routing mode is checked for a one-hot or empty word, since a design that merely wrote the addressed bit would leave stale ones elsewhere. Hold mode follows routing and zero modes to catch a design that reloads an older value, and the address is changed under hold before a write to catch one that writes in hold mode.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    // Operating modes, encoded as {clr, !en_n}
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_ZERO  = 2'b10,
        MODE_ROUTE = 2'b11
    } mode_e;

    typedef struct packed {
        logic en_n;
        logic clr;
    } ctrl_t;

    typedef struct packed {
        logic sel;
        logic din;
        logic cur;
    } cell_in_t;

    function automatic mode_e decode_mode(ctrl_t c);
        mode_e m;
        case ({c.clr, c.en_n})
            2'b00:   m = MODE_WRITE;
            2'b01:   m = MODE_HOLD;
            2'b10:   m = MODE_ROUTE;
            default: m = MODE_ZERO;
        endcase
        return m;
    endfunction

    function automatic logic cell_next(mode_e m, cell_in_t ci);
        logic n;
        case (m)
            MODE_WRITE: n = ci.sel ? ci.din : ci.cur;
            MODE_ROUTE: n = ci.sel & ci.din;
            MODE_ZERO:  n = 1'b0;
            default:    n = ci.cur;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sbr_mode_decode.sv
module sbr_mode_decode
    import sbr_pkg::*;
(
    input  logic  en_n,
    input  logic  clr,
    output mode_e mode
);
    ctrl_t ctrl;

    always_comb begin
        ctrl.en_n = en_n;
        ctrl.clr  = clr;
        mode      = decode_mode(ctrl);
    end
endmodule

// File: rtl/sbr_addr_decode.sv
module sbr_addr_decode #(
    parameter int WIDTH = 8,
    localparam int AW = $clog2(WIDTH)
) (
    input  logic [AW-1:0]    addr,
    output logic [WIDTH-1:0] sel
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_sel
        assign sel[i] = (addr == AW'(i));
    end
endmodule

// File: rtl/sbr_cell.sv
module sbr_cell
    import sbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  sel,
    input  logic  din,
    output logic  q
);
    cell_in_t ci;
    logic     q_nxt;

    always_comb begin
        ci.sel = sel;
        ci.din = din;
        ci.cur = q;
        q_nxt  = cell_next(mode, ci);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= q_nxt;
    end
endmodule

// File: rtl/sel_bit_register.sv
module sel_bit_register
    import sbr_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int AW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [AW-1:0]    addr,
    input  logic             en_n,
    input  logic             clr,
    output logic [WIDTH-1:0] q
);
    mode_e            mode;
    logic [WIDTH-1:0] sel;

    sbr_mode_decode u_mode (
        .en_n (en_n),
        .clr  (clr),
        .mode (mode)
    );

    sbr_addr_decode #(.WIDTH(WIDTH)) u_addr (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        sbr_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .sel  (sel[i]),
            .din  (din),
            .q    (q[i])
        );
    end
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
    parameter int WIDTH = 8,
    localparam int AW = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             din,
    input logic [AW-1:0]    addr,
    input logic             en_n,
    input logic             clr,
    input logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // R2
    hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (en_n && !clr) |=> (q == $past(q)));

    // R3
    write_target_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_n && !clr) |=> (q[$past(addr)] == $past(din)));

    // R4
    write_others_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_n && !clr) |=> (((q ^ $past(q)) & ~(ONE << $past(addr))) == '0));

    // R5
    route_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_n && clr) |=> ($onehot0(q) &&
            (q == ($past(din) ? (ONE << $past(addr)) : '0))));

    // R6
    zero_word_chk: assert property (@(posedge clk) disable iff (rst)
        (en_n && clr) |=> (q == '0));
endmodule

bind sel_bit_register sbr_checker #(.WIDTH(WIDTH)) chk_i (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .addr (addr),
    .en_n (en_n),
    .clr  (clr),
    .q    (q)
);

// File: tb/sel_bit_register_tb_top.sv
`timescale 1ns/1ps
module sel_bit_register_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       en_n = 1'b1;
    logic       clr = 1'b0;
    logic [7:0] q8;
    logic [3:0] q4;
    logic [7:0] exp8 = '0;
    logic [3:0] exp4 = '0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sel_bit_register #(.WIDTH(8)) dut_i (
        .clk(clk), .rst(rst), .din(din), .addr(addr),
        .en_n(en_n), .clr(clr), .q(q8)
    );

    sel_bit_register #(.WIDTH(4)) dut4_i (
        .clk(clk), .rst(rst), .din(din), .addr(addr[1:0]),
        .en_n(en_n), .clr(clr), .q(q4)
    );

    // Reference next state for an n-bit bank, computed from the requirements
    function automatic logic [7:0] ref_next(int n, logic [7:0] cur, logic d,
                                            logic [2:0] a, logic e_n, logic c);
        logic [7:0] r;
        int idx = int'(a) % n;
        r = cur;
        if (!e_n && !c)     r[idx] = d;
        else if (!e_n && c) begin r = '0; r[idx] = d; end
        else if (e_n && c)  r = '0;
        if (n < 8) r = r & ((8'd1 << n) - 8'd1);
        return r;
    endfunction

    function automatic string req_of(logic e_n, logic c, logic after_clr);
        if (!e_n && !c) return "R3 R4";
        if (!e_n && c)  return "R5";
        if (e_n && c)   return "R6";
        return after_clr ? "R7" : "R2";
    endfunction

    task automatic check8(string req, logic [7:0] exp);
        checks++;
        if (q8 !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected %b", req, q8, exp);
        end
    endtask

    task automatic check4(string req, logic [3:0] exp);
        checks++;
        if (q4 !== exp) begin
            errors++;
            $display("FAIL %s (R9 4-bit): q=%b expected %b", req, q4, exp);
        end
    endtask

    logic last_clr = 1'b0;

    // One clocked step: drive away from the edge, sample 1 ns after it
    task automatic step(logic d, logic [2:0] a, logic e_n, logic c);
        string req;
        @(negedge clk);
        din = d; addr = a; en_n = e_n; clr = c;
        req  = req_of(e_n, c, last_clr);
        exp8 = ref_next(8, exp8, d, a, e_n, c);
        exp4 = ref_next(4, {4'd0, exp4}, d, a, e_n, c)[3:0];
        @(posedge clk); #1;
        check8(req, exp8);
        check4(req, exp4);
        if (c) last_clr = 1'b1;
        else if (!e_n) last_clr = 1'b0;
    endtask

    initial begin
        int seed = 32'h5EED_0042;
        void'($urandom(seed));
        // R1: reset with hostile controls
        @(negedge clk);
        din = 1'b1; en_n = 1'b0; clr = 1'b1; addr = 3'd5;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check8("R1", 8'h00);
        check4("R1", 4'h0);
        @(negedge clk);
        rst = 1'b0; en_n = 1'b1; clr = 1'b0;
        // R8: walk addresses writing ones, bit k follows address k
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 3'(k), 1'b1, 1'b0);
            step(1'b1, 3'(k), 1'b0, 1'b0);
            checks++;
            if (q8 !== 8'((9'd1 << (k + 1)) - 9'd1)) begin
                errors++;
                $display("FAIL R8: q=%b expected %b", q8, 8'((9'd1 << (k + 1)) - 9'd1));
            end
        end
        // R2: hold ignores data and address
        for (int k = 0; k < 8; k++) step(k[0], 3'(7 - k), 1'b1, 1'b0);
        // R4: clear one bit in the middle
        step(1'b0, 3'd3, 1'b1, 1'b0);
        step(1'b0, 3'd3, 1'b0, 1'b0);
        // R5: route each address, then R7 hold keeps the routed word
        for (int k = 0; k < 8; k++) step(1'b1, 3'(k), 1'b0, 1'b1);
        step(1'b0, 3'd1, 1'b1, 1'b0);
        step(1'b1, 3'd6, 1'b1, 1'b0);
        step(1'b0, 3'd2, 1'b0, 1'b1);
        step(1'b1, 3'd2, 1'b1, 1'b0);
        // R6 then R7: zero and hold
        step(1'b1, 3'd4, 1'b0, 1'b0);
        step(1'b1, 3'd4, 1'b1, 1'b1);
        step(1'b1, 3'd7, 1'b1, 1'b0);
        // address moved under hold, then write (R3)
        step(1'b1, 3'd6, 1'b1, 1'b0);
        step(1'b1, 3'd6, 1'b0, 1'b0);
        // Random mix, address changed only while holding
        for (int k = 0; k < 600; k++) begin
            logic [2:0] a = 3'($urandom_range(0, 7));
            logic [1:0] m = 2'($urandom_range(0, 3));
            step(1'($urandom), a, 1'b1, 1'b0);
            step(1'($urandom), a, m[0], m[1]);
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule